// File: doc/BRIEF.md
# Software Transfer Launch and Module-Stop Control

This block is the processor-side control for launching data transfers by software on a transfer controller, plus the module-stop gate for that controller. A launch register holds an enable flag and a 7-bit vector number. Writing it with the flag set sends a one-cycle launch request to the transfer engine. The request carries the vector-table address derived from the vector number. When the engine reports that a software transfer has finished, the block either clears the flag or keeps it. The choice depends on a disable-select input and on whether the programmed count has run out. When the flag is kept, the block raises an end-of-transfer interrupt request. That request stays up until the disable-select input is taken low.

A second, 8-bit register holds the module-stop controls. Its bit 6 stops the transfer controller. While the engine reports itself busy, a write cannot set that bit. Once the bit is set, the controller enters module stop only when a bus cycle ends. Software reads both registers back through the same simple synchronous bus.

Top module: `swact_ctrl`

## Requirements
- R1: After reset the launch register reads 0x00 and the stop register reads 0x3F. The launch request, the interrupt request and the module-stop output are low, and the vector address is 0x0400.
- R2: The launch register sits at address 0 and the stop register at address 1. On a read, bit 7 of the launch register is the enable flag and bits 6..0 are the vector number. A written value reads back in the cycle after the write.
- R3: The vector address equals 0x0400 plus the stored vector number shifted left by one. For example, vector 0x10 gives 0x0420.
- R4: A write to address 0 with bit 7 set, made while `xfer_active` is low, produces a launch request high for exactly the following cycle. The same write made while `xfer_active` is high produces no request.
- R5: On `xfer_done` with `dis_sel` low and `cnt_zero` low, the enable flag clears and no interrupt request is raised.
- R6: On `xfer_done` with `dis_sel` high or `cnt_zero` high, the enable flag keeps its value. The interrupt request rises in the next cycle and stays high.
- R7: When `dis_sel` falls while the interrupt request is high, the interrupt request and the enable flag both clear at the next edge.
- R8: While `engine_busy` is high, a write of 1 to stop-register bit 6 leaves that bit at 0, and the other bits take the written data. A write of 0 to bit 6 always takes effect.
- R9: `mod_stop` rises only in the cycle after a `bus_cycle_end` pulse that arrives while stop bit 6 is set. It falls one cycle after bit 6 is cleared.
- R10: A `hw_standby` pulse reloads the stop register with 0x3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Hardware standby entry, reloads the stop register |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| xfer_active | input | 1 | A software-launched transfer is in flight |
| xfer_done | input | 1 | Pulse: software transfer finished |
| cnt_zero | input | 1 | Programmed transfer count has run out |
| dis_sel | input | 1 | Disable-select setting |
| engine_busy | input | 1 | Transfer controller is operating |
| bus_cycle_end | input | 1 | Pulse: current bus cycle ends |
| act_req | output | 1 | One-cycle launch request |
| act_vaddr | output | 16 | Vector-table address for the launch |
| swend_irq | output | 1 | End-of-software-transfer interrupt request |
| stop_vec | output | 8 | Module-stop register contents |
| mod_stop | output | 1 | Transfer controller is in module stop |

## Verification
A wrong flag state shows up in the readback of address 0 one cycle after the `xfer_done` pulse or the `dis_sel` fall. A wrong interrupt state shows up on `swend_irq` at that same edge. A bad vector register changes `act_vaddr` at once. A lost write protection appears as bit 6 of the stop readback in the cycle after the write. A premature module stop is visible on `mod_stop` one cycle after a write, before any `bus_cycle_end`.

// File: rtl/swact_pkg.sv
package swact_pkg;
  localparam int VEC_W     = 7;
  localparam int DATA_W    = 8;
  localparam int VADDR_W   = 16;
  localparam logic [VADDR_W-1:0] VEC_BASE = 16'h0400;
  localparam logic [DATA_W-1:0]  STOP_INIT = 8'h3F;
  localparam int STOP_BIT  = 6;

  typedef struct packed {
    logic             en;
    logic [VEC_W-1:0] vec;
  } launch_reg_t;
endpackage

// File: rtl/swact_rst_sync.sv
module swact_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/swact_launch.sv
module swact_launch
  import swact_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VEC_W:0]     wdata,
  input  logic               xfer_active,
  input  logic               xfer_done,
  input  logic               cnt_zero,
  input  logic               dis_sel,
  output launch_reg_t        reg_q,
  output logic               act_req,
  output logic [VADDR_W-1:0] act_vaddr,
  output logic               swend_irq
);
  launch_reg_t reg_d;
  logic        irq_d, req_d, dis_q, dis_fall;

  assign dis_fall = dis_q & ~dis_sel;

  always_comb begin
    reg_d = reg_q;
    irq_d = swend_irq;
    if (dis_fall && swend_irq) begin
      irq_d  = 1'b0;
      reg_d.en = 1'b0;
    end
    if (xfer_done) begin
      if (dis_sel || cnt_zero) irq_d    = 1'b1;
      else                     reg_d.en = 1'b0;
    end
    if (wr_en) begin
      reg_d.en  = wdata[VEC_W];
      reg_d.vec = wdata[VEC_W-1:0];
    end
    req_d = wr_en & wdata[VEC_W] & ~xfer_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q     <= '0;
      swend_irq <= 1'b0;
      act_req   <= 1'b0;
      dis_q     <= 1'b0;
    end else begin
      reg_q     <= reg_d;
      swend_irq <= irq_d;
      act_req   <= req_d;
      dis_q     <= dis_sel;
    end
  end

  assign act_vaddr = VEC_BASE + VADDR_W'({reg_q.vec, 1'b0});
endmodule

// File: rtl/swact_mstop.sv
module swact_mstop
  import swact_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_standby,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              engine_busy,
  input  logic              bus_cycle_end,
  output logic [DATA_W-1:0] stop_q,
  output logic              mod_stop
);
  logic [DATA_W-1:0] stop_d;
  logic              mod_d;

  always_comb begin
    stop_d = stop_q;
    if (hw_standby) begin
      stop_d = STOP_INIT;
    end else if (wr_en) begin
      stop_d = wdata;
      if (engine_busy) stop_d[STOP_BIT] = wdata[STOP_BIT] & stop_q[STOP_BIT];
    end
    mod_d = stop_q[STOP_BIT] & (mod_stop | bus_cycle_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q   <= STOP_INIT;
      mod_stop <= 1'b0;
    end else begin
      stop_q   <= stop_d;
      mod_stop <= mod_d;
    end
  end
endmodule

// File: rtl/swact_ctrl.sv
module swact_ctrl
  import swact_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int LAUNCH_AD = 0,
  parameter int STOP_AD   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_standby,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               xfer_active,
  input  logic               xfer_done,
  input  logic               cnt_zero,
  input  logic               dis_sel,
  input  logic               engine_busy,
  input  logic               bus_cycle_end,
  output logic               act_req,
  output logic [VADDR_W-1:0] act_vaddr,
  output logic               swend_irq,
  output logic [DATA_W-1:0]  stop_vec,
  output logic               mod_stop
);
  logic        rst_n_int, sel_launch, sel_stop;
  launch_reg_t launch_q;

  assign sel_launch = (bus_addr == ADDR_W'(LAUNCH_AD));
  assign sel_stop   = (bus_addr == ADDR_W'(STOP_AD));

  swact_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  swact_launch u_launch (
    .clk(clk), .rst_n(rst_n_int), .wr_en(bus_wr & sel_launch),
    .wdata(bus_wdata), .xfer_active(xfer_active), .xfer_done(xfer_done),
    .cnt_zero(cnt_zero), .dis_sel(dis_sel), .reg_q(launch_q),
    .act_req(act_req), .act_vaddr(act_vaddr), .swend_irq(swend_irq)
  );

  swact_mstop u_mstop (
    .clk(clk), .rst_n(rst_n_int), .hw_standby(hw_standby),
    .wr_en(bus_wr & sel_stop), .wdata(bus_wdata), .engine_busy(engine_busy),
    .bus_cycle_end(bus_cycle_end), .stop_q(stop_vec), .mod_stop(mod_stop)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_launch)    bus_rdata = launch_q;
    else if (sel_stop) bus_rdata = stop_vec;
  end
endmodule

// File: rtl/swact_ctrl_chk.sv
module swact_ctrl_chk
  import swact_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int LAUNCH_AD = 0,
  parameter int STOP_AD   = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               xfer_active,
  input logic               xfer_done,
  input logic               dis_sel,
  input logic               engine_busy,
  input logic               bus_cycle_end,
  input logic               hw_standby,
  input logic               act_req,
  input logic [VADDR_W-1:0] act_vaddr,
  input logic               swend_irq,
  input logic [DATA_W-1:0]  stop_vec,
  input logic               mod_stop
);
  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_req |=> !act_req);

  p_req_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_req |-> $past(bus_wr && bus_addr == ADDR_W'(LAUNCH_AD)
                      && bus_wdata[VEC_W] && !xfer_active));

  p_vaddr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_req |-> act_vaddr == VEC_BASE + VADDR_W'({$past(bus_wdata[VEC_W-1:0]), 1'b0}));

  p_stop_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(STOP_AD) && engine_busy && !stop_vec[STOP_BIT])
      |=> !stop_vec[STOP_BIT]);

  p_mstop_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_stop) |-> $past(bus_cycle_end));

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swend_irq && $fell(dis_sel) && !xfer_done) |=> !swend_irq);

  p_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_standby |=> stop_vec == STOP_INIT);
endmodule

bind swact_ctrl swact_ctrl_chk #(
  .ADDR_W(ADDR_W), .LAUNCH_AD(LAUNCH_AD), .STOP_AD(STOP_AD)
) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .xfer_active(xfer_active), .xfer_done(xfer_done),
  .dis_sel(dis_sel), .engine_busy(engine_busy), .bus_cycle_end(bus_cycle_end),
  .hw_standby(hw_standby), .act_req(act_req), .act_vaddr(act_vaddr),
  .swend_irq(swend_irq), .stop_vec(stop_vec), .mod_stop(mod_stop)
);

// File: tb/test_swact_ctrl.sv
`timescale 1ns/1ps
module test_swact_ctrl;
  localparam int S_RDATA = 0, S_REQ = 1, S_VADDR = 2, S_IRQ = 3, S_MSTOP = 4;

  typedef struct {
    int          cyc;
    int          sel;
    logic [15:0] val;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_standby = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        xfer_active = 1'b0, xfer_done = 1'b0, cnt_zero = 1'b0, dis_sel = 1'b0;
  logic        engine_busy = 1'b0, bus_cycle_end = 1'b0;
  logic [7:0]  bus_rdata, stop_vec;
  logic        act_req, swend_irq, mod_stop;
  logic [15:0] act_vaddr;

  int   cyc = 0, checks = 0, errors = 0;
  bit   finished = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  swact_ctrl i_swact_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_active(xfer_active), .xfer_done(xfer_done), .cnt_zero(cnt_zero),
    .dis_sel(dis_sel), .engine_busy(engine_busy), .bus_cycle_end(bus_cycle_end),
    .act_req(act_req), .act_vaddr(act_vaddr), .swend_irq(swend_irq),
    .stop_vec(stop_vec), .mod_stop(mod_stop)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_at(int dly, int sel, logic [15:0] v, string r);
    sb.push_back('{cyc + dly, sel, v, r});
  endtask

  task automatic clr();
    tick();
    bus_wr = 1'b0; xfer_done = 1'b0; cnt_zero = 1'b0;
    bus_cycle_end = 1'b0; hw_standby = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    tick();
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
  endtask

  function automatic logic [15:0] actual(int sel);
    case (sel)
      S_RDATA: return {8'h00, bus_rdata};
      S_REQ:   return {15'd0, act_req};
      S_VADDR: return act_vaddr;
      S_IRQ:   return {15'd0, swend_irq};
      default: return {15'd0, mod_stop};
    endcase
  endfunction

  // monitor: pops due items and compares
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc <= cyc) begin
        checks++;
        if (sb[i].cyc < cyc || actual(sb[i].sel) !== sb[i].val) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h cyc=%0d",
                   sb[i].req, sb[i].sel, actual(sb[i].sel), sb[i].val, cyc);
        end
        sb.delete(i);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1: reset state
    bus_addr = 4'd0;
    expect_at(0, S_RDATA, 16'h00, "R1");
    expect_at(0, S_REQ, 16'h0, "R1");
    expect_at(0, S_IRQ, 16'h0, "R1");
    expect_at(0, S_MSTOP, 16'h0, "R1");
    expect_at(0, S_VADDR, 16'h0400, "R1");
    tick(); bus_addr = 4'd1;
    expect_at(0, S_RDATA, 16'h3F, "R1");
    // R4/R3/R2: launch with vector 0x10
    wr(4'd0, 8'h90);
    expect_at(1, S_REQ, 16'h1, "R4");
    expect_at(1, S_VADDR, 16'h0420, "R3");
    expect_at(1, S_RDATA, 16'h90, "R2");
    expect_at(2, S_REQ, 16'h0, "R4");
    clr(); clr();
    // R4: no request while a transfer is in flight
    xfer_active = 1'b1;
    wr(4'd0, 8'hFF);
    expect_at(1, S_REQ, 16'h0, "R4");
    expect_at(1, S_VADDR, 16'h04FE, "R3");
    expect_at(1, S_RDATA, 16'hFF, "R2");
    clr(); xfer_active = 1'b0;
    wr(4'd0, 8'h85);
    expect_at(1, S_REQ, 16'h1, "R4");
    expect_at(1, S_VADDR, 16'h040A, "R3");
    clr(); clr();
    // R5: auto-clear
    tick(); xfer_done = 1'b1; dis_sel = 1'b0; cnt_zero = 1'b0;
    expect_at(1, S_RDATA, 16'h05, "R5");
    expect_at(1, S_IRQ, 16'h0, "R5");
    clr();
    // R6/R7: hold with dis_sel set, clear on its fall
    wr(4'd0, 8'h83); clr();
    tick(); dis_sel = 1'b1; xfer_done = 1'b1;
    expect_at(1, S_RDATA, 16'h83, "R6");
    expect_at(1, S_IRQ, 16'h1, "R6");
    expect_at(3, S_IRQ, 16'h1, "R6");
    clr(); clr(); clr();
    tick(); dis_sel = 1'b0;
    expect_at(1, S_IRQ, 16'h0, "R7");
    expect_at(1, S_RDATA, 16'h03, "R7");
    clr();
    // R6: hold on count completion
    wr(4'd0, 8'h84); clr();
    tick(); xfer_done = 1'b1; cnt_zero = 1'b1;
    expect_at(1, S_RDATA, 16'h84, "R6");
    expect_at(1, S_IRQ, 16'h1, "R6");
    clr();
    tick(); dis_sel = 1'b1;
    tick(); dis_sel = 1'b0;
    expect_at(1, S_IRQ, 16'h0, "R7");
    expect_at(1, S_RDATA, 16'h04, "R7");
    clr();
    // R8: stop bit protection
    engine_busy = 1'b1;
    wr(4'd1, 8'h7F);
    expect_at(1, S_RDATA, 16'h3F, "R8");
    expect_at(1, S_MSTOP, 16'h0, "R8");
    clr(); engine_busy = 1'b0;
    wr(4'd1, 8'h40);
    expect_at(1, S_RDATA, 16'h40, "R8");
    expect_at(2, S_MSTOP, 16'h0, "R9");
    clr(); clr();
    // R9: stop only at bus-cycle end
    tick(); bus_cycle_end = 1'b1;
    expect_at(1, S_MSTOP, 16'h1, "R9");
    clr(); engine_busy = 1'b1;
    wr(4'd1, 8'h00);
    expect_at(1, S_RDATA, 16'h00, "R8");
    expect_at(2, S_MSTOP, 16'h0, "R9");
    clr(); clr(); engine_busy = 1'b0;
    // R10: hardware standby reload
    wr(4'd1, 8'hC0);
    expect_at(1, S_RDATA, 16'hC0, "R2");
    clr();
    tick(); hw_standby = 1'b1;
    expect_at(1, S_RDATA, 16'h3F, "R10");
    clr();
    repeat (4) tick();
    foreach (sb[i]) begin
      errors++; checks++;
      $display("FAIL %s actual=unchecked expected=%h", sb[i].req, sb[i].val);
    end
    finished = 1'b1;
    summary();
  end
endmodule